// File: doc/BRIEF.md
# Multichannel Spike Snippet Capture

This block takes a time-multiplexed stream of 8-bit neural samples for a group of channels, 16 by default. Samples arrive in channel order, and each one carries its channel number. When a channel's sample rises above a programmable threshold, the block starts capturing a waveform window of 40 samples on that channel. The window begins with the sample that crossed. When the window is complete, the block sends a framed record out of an 8-bit byte port. The record holds the channel number, a 32-bit frame timestamp and the captured samples. Several instances can run side by side, each serving its own group of channels.

Windows are held in a small shared pool of record slots. A slot is claimed when a spike is detected and released when the last byte of its record leaves the port. Finished records wait in a queue and leave in the order they completed. A raw bypass setting connects the input stream straight to the output port and suspends detection.

Both streams use valid/ready. A byte moves on a clock edge where valid and ready are both high. While the sink holds `out_ready` low, `out_valid` stays high and `out_data` and `out_last` keep their values. In snippet mode the input never back-pressures. In bypass mode, `in_ready` follows `out_ready`. `bypass` may only change while no record is waiting and no channel is capturing.

Top module: `spike_snippet`

## Requirements
- R1: A sample starts a spike on an idle channel only when its value, taken as unsigned, is strictly greater than `thresh`. A sample equal to the threshold does not start one.
- R2: A spike's window is the crossing sample plus the next 39 accepted samples of that channel. While the window runs, the channel is refractory: samples above the threshold are captured but start no new spike. The sample after the window can start a new spike.
- R3: A record is 45 bytes long. Byte 0 is the channel number, zero-extended. Bytes 1 to 4 are the timestamp, most significant byte first. Bytes 5 to 44 are the window samples in arrival order. `out_last` is high only on byte 44.
- R4: The timestamp counts frames. It is 0 after reset and increments once after each accepted sample of channel 15, wrapping at 32 bits. A record carries the value the counter held when its crossing sample was accepted.
- R5: Records leave in the order their windows completed. Every stored record is delivered exactly once.
- R6: In snippet mode, `out_valid` and `rec_avail` are high exactly while at least one completed record has not been fully sent. A stalled byte holds its value until it is accepted.
- R7: Up to 4 records can be held at once, counting both capturing and waiting windows. A spike detected while all 4 slots are in use is dropped and produces no record, but its channel still serves the 40-sample refractory window. The `overflow` flag is then set and stays set until reset.
- R8: With `bypass` high, the output follows the input combinationally: `out_valid` = `in_valid`, `out_data` = `in_data`, `out_last` low. No spike is detected. Capture resumes once `bypass` is low again.
- R9: In snippet mode `in_ready` is constantly high.
- R10: After reset, `out_valid`, `rec_avail` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | 8 | Spike threshold, unsigned |
| bypass | input | 1 | Raw pass-through mode |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted |
| in_chan | input | 4 | Channel number of the input sample |
| in_data | input | 8 | Input sample |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of a record |
| rec_avail | output | 1 | A completed record is waiting or being sent |
| overflow | output | 1 | Sticky: a spike was dropped for lack of a slot |

## Verification
Timing of each result:
- A record's first byte is valid in the cycle after the clock edge that accepts the 40th sample of its window.
- `rec_avail`, the timestamp and `overflow` change one edge after the sample or byte handshake that causes them.
- The bypass outputs are combinational in the same cycle.

The bench drives its inputs at the falling edge and samples 1 ns later. It checks these outputs against the state its model held after the previous rising edge. It then advances its model in the same order as the hardware: slot claim before slot release, and timestamp increment after capture.

// File: rtl/snip_pkg.sv
package snip_pkg;
  // Which part of a record the serializer is emitting.
  typedef enum logic [1:0] {
    FLD_CHAN = 2'd0,
    FLD_TS   = 2'd1,
    FLD_SAMP = 2'd2
  } rec_field_e;
endpackage

// File: rtl/snip_chan.sv
// Per-channel detector: tracks one capture window and produces write strobes.
module snip_chan #(
  parameter int WIN = 40,
  parameter int SW  = 2,
  localparam int IW = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [7:0]    samp,
  input  logic [7:0]    thresh,
  input  logic          slot_free,
  input  logic [SW-1:0] slot_new,
  output logic          start,
  output logic          done,
  output logic          wr_en,
  output logic [SW-1:0] wr_slot,
  output logic [IW-1:0] wr_idx
);
  localparam logic [IW-1:0] LAST = IW'(WIN - 1);

  logic          busy;
  logic          keep;
  logic [IW-1:0] cnt;
  logic [SW-1:0] slot;

  assign start   = hit & ~busy & (samp > thresh);
  assign done    = hit & busy & keep & (cnt == LAST);
  assign wr_en   = (start & slot_free) | (hit & busy & keep);
  assign wr_slot = busy ? slot : slot_new;
  assign wr_idx  = busy ? cnt : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      keep <= 1'b0;
      cnt  <= '0;
      slot <= '0;
    end else if (start) begin
      busy <= 1'b1;
      keep <= slot_free;
      cnt  <= IW'(1);
      slot <= slot_new;
    end else if (hit && busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + IW'(1);
      end
    end
  end

  // R2: window index never runs past the last sample
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST));
endmodule

// File: rtl/snip_pool.sv
// Record slot pool: sample memory, per-slot header fields, completion queue.
module snip_pool #(
  parameter int NSLOT = 4,
  parameter int WIN   = 40,
  parameter int CHW   = 4,
  parameter int TSW   = 32,
  localparam int SW = $clog2(NSLOT),
  localparam int IW = $clog2(WIN),
  localparam int AW = $clog2(NSLOT * WIN),
  localparam int CW = SW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc,
  input  logic [CHW-1:0] alloc_chan,
  input  logic [TSW-1:0] alloc_ts,
  output logic           free_any,
  output logic [SW-1:0]  free_idx,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_slot,
  input  logic [IW-1:0]  wr_idx,
  input  logic [7:0]     wr_data,
  input  logic           push,
  input  logic [SW-1:0]  push_slot,
  input  logic           pop,
  output logic           head_valid,
  output logic [CHW-1:0] head_chan,
  output logic [TSW-1:0] head_ts,
  input  logic [IW-1:0]  rd_idx,
  output logic [7:0]     rd_data
);
  logic [NSLOT-1:0] used;
  logic [7:0]       mem   [NSLOT*WIN];
  logic [CHW-1:0]   mchan [NSLOT];
  logic [TSW-1:0]   mts   [NSLOT];
  logic [SW-1:0]    q     [NSLOT];
  logic [SW-1:0]    wp, rp, head_slot;
  logic [CW-1:0]    cnt;

  function automatic logic [AW-1:0] addr(input logic [SW-1:0] s, input logic [IW-1:0] i);
    return AW'(s) * AW'(WIN) + AW'(i);
  endfunction

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] p);
    return (p == SW'(NSLOT - 1)) ? '0 : p + SW'(1);
  endfunction

  assign free_any = ~&used;
  always_comb begin
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (!used[i]) free_idx = SW'(i);
  end

  assign head_valid = (cnt != '0);
  assign head_slot  = q[rp];
  assign head_chan  = mchan[head_slot];
  assign head_ts    = mts[head_slot];
  assign rd_data    = mem[addr(head_slot, rd_idx)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
    end else begin
      if (alloc) used[free_idx] <= 1'b1;
      if (pop) begin
        used[head_slot] <= 1'b0;
        rp <= nxt(rp);
      end
      if (push) wp <= nxt(wp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr(wr_slot, wr_idx)] <= wr_data;
    if (alloc) begin
      mchan[free_idx] <= alloc_chan;
      mts[free_idx]   <= alloc_ts;
    end
    if (push) q[wp] <= push_slot;
  end

  // R5: a completing window always finds room in the queue
  p_push_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(NSLOT)));
  // R6: a record is only released while one is queued
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/snip_out.sv
// Serializes the head record: channel byte, timestamp MSB first, samples.
module snip_out import snip_pkg::*; #(
  parameter int WIN = 40,
  parameter int CHW = 4,
  parameter int TSW = 32,
  localparam int TSB = TSW / 8,
  localparam int REC = 1 + TSB + WIN,
  localparam int BW  = $clog2(REC),
  localparam int IW  = $clog2(WIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           head_valid,
  input  logic [CHW-1:0] head_chan,
  input  logic [TSW-1:0] head_ts,
  input  logic [7:0]     rd_data,
  output logic [IW-1:0]  rd_idx,
  output logic           o_valid,
  input  logic           o_ready,
  output logic [7:0]     o_data,
  output logic           o_last,
  output logic           pop
);
  logic [BW-1:0] bidx;
  logic [7:0]    ts_byte;
  rec_field_e    fld;

  always_comb begin
    if (bidx == '0)              fld = FLD_CHAN;
    else if (bidx <= BW'(TSB))   fld = FLD_TS;
    else                         fld = FLD_SAMP;
  end

  always_comb begin
    ts_byte = '0;
    for (int k = 0; k < TSB; k++)
      if (bidx == BW'(k + 1)) ts_byte = head_ts[8*(TSB-1-k) +: 8];
  end

  assign rd_idx  = IW'(bidx - BW'(1 + TSB));
  assign o_valid = head_valid;
  assign o_last  = (bidx == BW'(REC - 1));
  assign pop     = o_valid & o_ready & o_last;

  always_comb begin
    case (fld)
      FLD_CHAN: o_data = 8'(head_chan);
      FLD_TS:   o_data = ts_byte;
      default:  o_data = rd_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                bidx <= '0;
    else if (o_valid && o_ready) bidx <= o_last ? '0 : bidx + BW'(1);
  end

  // R3: byte index stays inside one record
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bidx <= BW'(REC - 1));
endmodule

// File: rtl/spike_snippet.sv
module spike_snippet #(
  parameter int NCH   = 16,
  parameter int WIN   = 40,
  parameter int NSLOT = 4,
  parameter int TSW   = 32,
  localparam int CHW = $clog2(NCH),
  localparam int SW  = $clog2(NSLOT),
  localparam int IW  = $clog2(WIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     thresh,
  input  logic           bypass,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CHW-1:0] in_chan,
  input  logic [7:0]     in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  output logic           out_last,
  output logic           rec_avail,
  output logic           overflow
);
  logic           in_fire;
  logic [NCH-1:0] hit_v, start_v, done_v, wr_v;
  logic [SW-1:0]  wslot_v [NCH];
  logic [IW-1:0]  widx_v  [NCH];
  logic           free_any, alloc, start_sel;
  logic [SW-1:0]  free_idx;
  logic [TSW-1:0] ts;
  logic           head_valid, pop;
  logic [CHW-1:0] head_chan;
  logic [TSW-1:0] head_ts;
  logic [IW-1:0]  rd_idx;
  logic [7:0]     rd_data, rec_data;
  logic           rec_valid, rec_last;

  assign in_ready = bypass ? out_ready : 1'b1;
  assign in_fire  = in_valid & in_ready;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hit_v[g] = in_fire & ~bypass & (in_chan == CHW'(g));
    snip_chan #(.WIN(WIN), .SW(SW)) u_ch (
      .clk(clk), .rst_n(rst_n), .hit(hit_v[g]), .samp(in_data), .thresh(thresh),
      .slot_free(free_any), .slot_new(free_idx), .start(start_v[g]), .done(done_v[g]),
      .wr_en(wr_v[g]), .wr_slot(wslot_v[g]), .wr_idx(widx_v[g])
    );
  end

  assign start_sel = |start_v;
  assign alloc     = start_sel & free_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts       <= '0;
      overflow <= 1'b0;
    end else begin
      if (in_fire && in_chan == CHW'(NCH - 1)) ts <= ts + TSW'(1);
      if (start_sel && !free_any) overflow <= 1'b1;
    end
  end

  snip_pool #(.NSLOT(NSLOT), .WIN(WIN), .CHW(CHW), .TSW(TSW)) u_pool (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .alloc_chan(in_chan), .alloc_ts(ts),
    .free_any(free_any), .free_idx(free_idx), .wr_en(|wr_v), .wr_slot(wslot_v[in_chan]),
    .wr_idx(widx_v[in_chan]), .wr_data(in_data), .push(|done_v),
    .push_slot(wslot_v[in_chan]), .pop(pop), .head_valid(head_valid),
    .head_chan(head_chan), .head_ts(head_ts), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  snip_out #(.WIN(WIN), .CHW(CHW), .TSW(TSW)) u_out (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_chan(head_chan),
    .head_ts(head_ts), .rd_data(rd_data), .rd_idx(rd_idx), .o_valid(rec_valid),
    .o_ready(out_ready & ~bypass), .o_data(rec_data), .o_last(rec_last), .pop(pop)
  );

  assign rec_avail = head_valid;
  assign out_valid = bypass ? in_valid : rec_valid;
  assign out_data  = bypass ? in_data  : rec_data;
  assign out_last  = bypass ? 1'b0     : rec_last;

  // R6: a stalled record byte is held
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n || bypass)
    (rec_valid && !out_ready) |=> (rec_valid && $stable(rec_data) && $stable(rec_last)));
  // R7: overflow flag is sticky
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: tb/tb_spike_snippet.sv
`timescale 1ns/1ps
module tb_spike_snippet;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bypass, in_valid, in_ready, out_valid, out_ready, out_last, rec_avail, overflow;
  logic [7:0] thresh, in_data, out_data;
  logic [3:0] in_chan;

  spike_snippet dut (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .bypass(bypass), .in_valid(in_valid),
    .in_ready(in_ready), .in_chan(in_chan), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .rec_avail(rec_avail), .overflow(overflow)
  );

  int total = 0, bad = 0;
  bit wd = 0;
  bit mode = 0;
  bit mbusy[16], mkeep[16];
  int mcnt[16];
  logic [31:0] mts = 0;
  int used = 0, pend = 0, pos = 0, recs = 0;
  bit movf = 0;
  logic [7:0] rb[16][45];
  logic [8:0] expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit any_busy();
    for (int i = 0; i < 16; i++) if (mbusy[i]) return 1;
    return 0;
  endfunction

  task automatic tick(input bit v, input logic [7:0] d, input bit r);
    bit rdy_e, rel, fire;
    int uo, c;
    logic [8:0] e;
    @(negedge clk);
    bypass = mode; in_valid = v; in_data = d; in_chan = pos[3:0]; out_ready = r;
    #1;
    rdy_e = mode ? r : 1'b1;
    rel = 0;
    chk(in_ready == rdy_e, "R9 in_ready", in_ready, rdy_e);
    chk(rec_avail == (pend > 0), "R6 rec_avail", rec_avail, pend > 0);
    chk(overflow == movf, "R7 overflow", overflow, movf);
    if (mode) begin
      chk(out_valid == v && out_data == d && !out_last, "R8 bypass",
          {out_last, out_valid, out_data}, {1'b0, v, d});
    end else begin
      chk(out_valid == (pend > 0), "R6 out_valid", out_valid, pend > 0);
      if (out_valid && r) begin
        if (expq.size() == 0) chk(0, "R5 unexpected byte", out_data, -1);
        else begin
          e = expq.pop_front();
          chk({out_last, out_data} == e, "R3/R4/R5 record byte", {out_last, out_data}, e);
          if (e[8]) begin rel = 1; recs++; end
        end
      end
    end
    fire = v && rdy_e;
    uo = used;
    c = pos;
    if (fire && !mode) begin
      if (!mbusy[c]) begin
        if (d > thresh) begin
          mbusy[c] = 1; mcnt[c] = 1; mkeep[c] = (uo < 4);
          if (mkeep[c]) begin
            used++;
            rb[c][0] = 8'(c);
            rb[c][1] = mts[31:24]; rb[c][2] = mts[23:16];
            rb[c][3] = mts[15:8];  rb[c][4] = mts[7:0];
            rb[c][5] = d;
          end else movf = 1;
        end
      end else begin
        if (mkeep[c]) rb[c][5 + mcnt[c]] = d;
        if (mcnt[c] == 39) begin
          mbusy[c] = 0;
          if (mkeep[c]) begin
            for (int i = 0; i < 45; i++) expq.push_back({i == 44, rb[c][i]});
            pend++;
          end
        end else mcnt[c]++;
      end
    end
    if (rel) begin used--; pend--; end
    if (fire) begin
      if (pos == 15) mts++;
      pos = (pos + 1) % 16;
    end
  endtask

  // one frame; channels a and b get va/vb, the rest a quiet level
  task automatic frm(input int a, input logic [7:0] va, input int b, input logic [7:0] vb, input bit r);
    for (int ch = 0; ch < 16; ch++)
      tick(1, (ch == a) ? va : (ch == b) ? vb : 8'd10, r);
  endtask

  task automatic drain();
    while (any_busy() || pend > 0) tick(1, 8'd10, 1);
    while (pos != 0) tick(1, 8'd10, 1);
  endtask

  task automatic run();
    int r0;
    void'($urandom(32'd1234));
    rst_n = 0; thresh = 8'd100; bypass = 0; in_valid = 0; in_data = 0; in_chan = 0; out_ready = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!out_valid, "R10 out_valid after reset", out_valid, 0);
    chk(!rec_avail, "R10 rec_avail after reset", rec_avail, 0);
    chk(!overflow, "R10 overflow after reset", overflow, 0);
    // R1: equal value on ch3 ignored, ch5 crosses; R2: high samples in window no retrigger
    frm(3, 8'd100, 5, 8'd101, 1);
    repeat (39) frm(5, 8'd250, 5, 8'd250, 1);
    frm(99, 0, 99, 0, 1);
    drain();
    chk(recs == 1, "R1/R2 single record", recs, 1);
    // R2: crossing right after a window retriggers
    frm(5, 8'd101, 99, 0, 1);
    repeat (39) frm(99, 0, 99, 0, 1);
    drain();
    chk(recs == 2, "R2 retrigger after window", recs, 2);
    // random traffic with back-pressure
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      d = ($urandom % 100 < 2) ? 8'(101 + $urandom % 155) : 8'($urandom % 101);
      tick(($urandom % 10) < 8, d, ($urandom % 10) < 7);
    end
    drain();
    chk(expq.size() == 0, "R5 all records delivered", expq.size(), 0);
    // R7: six spikes with four slots and a stalled sink
    r0 = recs;
    for (int ch = 0; ch < 16; ch++) tick(1, (ch < 6) ? 8'd200 : 8'd10, 0);
    repeat (40) frm(99, 0, 99, 0, 0);
    chk(overflow == 1'b1, "R7 overflow set", overflow, 1);
    drain();
    chk(recs - r0 == 4, "R7 dropped spikes yield no record", recs - r0, 4);
    // R8: bypass
    mode = 1;
    for (int i = 0; i < 80; i++) tick(($urandom % 4) != 0, 8'($urandom), ($urandom % 3) != 0);
    mode = 0;
    while (pos != 0) tick(1, 8'd10, 1);
    repeat (3) frm(99, 0, 99, 0, 1);
    chk(recs - r0 == 4 && !rec_avail, "R8 no capture in bypass", recs - r0, 4);
    frm(9, 8'd180, 99, 0, 1);
    repeat (39) frm(99, 0, 99, 0, 1);
    drain();
    chk(recs - r0 == 5, "R8 capture resumes", recs - r0, 5);
  endtask

  initial begin
    fork
      run();
      begin #1000000; wd = 1; end
    join_any
    if (wd) begin
      total++; bad++;
      $display("FAIL watchdog R5 act=%0d exp=%0d", 1, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule